// File: doc/BRIEF.md
# Test-Mode Ratio Clock Divider

This block drives every clock group of a motherboard clock generator from a single external test clock, so that a tester can check each output at an exact integer ratio of a clock it controls. A 3-bit select code picks one of three modes: all outputs disabled (high impedance), test-ratio mode, or normal mode. In normal mode the derived clocks are held low and a flag tells the surrounding logic that the synthesized clocks own the pins.

In test-ratio mode the processor, memory and serial-bus groups run at half the test clock, the 66 MHz group at one third, the peripheral-bus group at one eighth, and the reference group at the test clock itself. The interrupt-controller group runs at one sixteenth or one eighth, chosen by a strap pin captured once after reset. Every divider counts from one shared phase counter whose period (48 test-clock cycles) is a multiple of every ratio. A select change is therefore applied only on the edge where that counter wraps, so all derived clocks start and stop together.

Top module: `tmr_ratio_div`

## Requirements
- R1: While rst_n is low, grp_oe is 0, normal_mode is 0 and every clock output is low.
- R2: With sel = 3'b000 applied, grp_oe is 0, normal_mode is 0 and all clock outputs stay low.
- R3: With sel = 3'b001 applied, grp_oe is all ones and normal_mode is 0. cpu_clk, sdram_clk and usb_clk run at tclk/2 and are high during even phases.
- R4: In test mode, mid_clk runs at tclk/3 and is high for 1.5 of every 3 tclk cycles. It rises on the tclk rising edge of phases that are multiples of 3 and falls on the tclk falling edge one cycle later.
- R5: In test mode, pci_clk runs at tclk/8 and is high for phases 0 to 3 modulo 8. ref_clk follows tclk.
- R6: In test mode, apic_clk runs at tclk/16 (high for phases 0 to 7 modulo 16) when the captured strap is 0. It runs at tclk/8 (equal to pci_clk) when the strap is 1. Every apic_clk rising edge coincides with a pci_clk rising edge.
- R7: strap is captured on the first tclk rising edge after reset release. Later changes on strap have no effect until the next reset.
- R8: Any sel code from 3'b010 to 3'b111, once applied, gives grp_oe all ones, normal_mode 1 and all clock outputs low.
- R9: sel is registered on each tclk rising edge. A new mode takes effect only on the alignment edges, which are tclk rising edges 48, 96, 144, … counted from reset release. On entry to test mode every derived clock rises on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tclk | input | 1 | External test clock; all dividers run from it |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 3 | Mode select code |
| strap | input | 1 | Ratio strap for the interrupt-controller group, captured after reset |
| cpu_clk | output | 1 | Processor group clock |
| sdram_clk | output | 1 | Memory group clock |
| usb_clk | output | 1 | Serial-bus group clock |
| mid_clk | output | 1 | 66 MHz group clock (divide by 3) |
| pci_clk | output | 1 | Peripheral-bus group clock |
| ref_clk | output | 1 | Reference group clock |
| apic_clk | output | 1 | Interrupt-controller group clock |
| grp_oe | output | 7 | Per-group output enable: bit 0 cpu, 1 sdram, 2 usb, 3 mid, 4 pci, 5 ref, 6 apic |
| normal_mode | output | 1 | High while a normal-mode code is applied |

## Verification
A sel value present before rising edge 47 after reset release is due on rising edge 48. grp_oe, normal_mode and the first derived-clock edges all change on that edge, and the bench checks edge 47 for the old state and edge 48 for the new one. The bench counts tclk rising edges from reset release and derives the phase from that count. It samples every output 2 ns after each rising edge (first half of the cycle) and again 7 ns after it (after the falling edge). This catches the half-cycle fall of mid_clk and the gated ref_clk. A sel change made mid-window is checked as still inactive on the cycle before the next multiple of 48 and active on the multiple itself.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NGROUP       = 7;
    localparam int SEL_W        = 3;
    localparam int ALIGN_PERIOD = 48;
    localparam int PHASE_W      = $clog2(ALIGN_PERIOD);

    // log2 of the power-of-two ratios
    localparam int LOG2_FAST      = 1;   // /2 groups
    localparam int LOG2_PCI       = 3;   // /8
    localparam int LOG2_APIC_SLOW = 4;   // /16

    localparam int G_CPU   = 0;
    localparam int G_SDRAM = 1;
    localparam int G_USB   = 2;
    localparam int G_MID   = 3;
    localparam int G_PCI   = 4;
    localparam int G_REF   = 5;
    localparam int G_APIC  = 6;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_TEST = 2'd1,
        MODE_RUN  = 2'd2
    } mode_e;

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        mode_e              mode;
        logic [SEL_W-1:0]   sel;
        logic               strap;
        logic               armed;
    } ctl_t;
endpackage

// File: rtl/tmr_sel_decode.sv
module tmr_sel_decode
    import tmr_pkg::*;
#(
    parameter int             W         = SEL_W,
    parameter logic [W-1:0]   CODE_OFF  = '0,
    parameter logic [W-1:0]   CODE_TEST = W'(1)
) (
    input  logic [W-1:0] code,
    output mode_e        mode
);
    always_comb begin
        if (code == CODE_OFF) begin
            mode = MODE_OFF;
        end else if (code == CODE_TEST) begin
            mode = MODE_TEST;
        end else begin
            mode = MODE_RUN;
        end
    end
endmodule

// File: rtl/tmr_half_div.sv
module tmr_half_div (
    input  logic clk,
    input  logic rst_n,
    input  logic run_nxt,
    input  logic half_bit,
    output logic clk_o
);
    logic q_d, q_q;

    always_comb begin
        q_d = run_nxt & ~half_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= 1'b0;
        end else begin
            q_q <= q_d;
        end
    end

    assign clk_o = q_q;
endmodule

// File: rtl/tmr_div3.sv
module tmr_div3 #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_nxt,
    output logic clk_o
);
    localparam int CNT_W = $clog2(DIV);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pos;
    } d3_t;

    d3_t  st_d, st_q;
    logic neg_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = (st_q.cnt == CNT_LAST) ? '0 : st_q.cnt + 1'b1;
        st_d.pos = run_nxt & (st_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // half-cycle extension: stretches the one-cycle pulse to 1.5 cycles
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_q <= 1'b0;
        end else begin
            neg_q <= st_q.pos;
        end
    end

    assign clk_o = st_q.pos | neg_q;

    // R4: the rising-edge pulse lasts exactly one cycle
    p_mid_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pos |=> !st_q.pos);
endmodule

// File: rtl/tmr_ratio_div.sv
module tmr_ratio_div
    import tmr_pkg::*;
(
    input  logic              tclk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic              strap,
    output logic              cpu_clk,
    output logic              sdram_clk,
    output logic              usb_clk,
    output logic              mid_clk,
    output logic              pci_clk,
    output logic              ref_clk,
    output logic              apic_clk,
    output logic [NGROUP-1:0] grp_oe,
    output logic              normal_mode
);
    localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(ALIGN_PERIOD - 1);
    localparam int NPOW = 6;
    localparam int HB [NPOW] = '{LOG2_FAST - 1, LOG2_FAST - 1, LOG2_FAST - 1,
                                 LOG2_PCI - 1, LOG2_PCI - 1, LOG2_APIC_SLOW - 1};

    ctl_t  st_d, st_q;
    mode_e dec_mode;
    logic  run_nxt;
    logic  ref_run_q;
    logic [NPOW-1:0] p2_clk;

    tmr_sel_decode u_dec (
        .code (st_q.sel),
        .mode (dec_mode)
    );

    always_comb begin
        st_d       = st_q;
        st_d.sel   = sel;
        st_d.phase = (st_q.phase == PHASE_LAST) ? '0 : st_q.phase + 1'b1;
        if (st_q.phase == PHASE_LAST) begin
            st_d.mode = dec_mode;
        end
        if (st_q.armed) begin
            st_d.strap = strap;
            st_d.armed = 1'b0;
        end
        run_nxt = (st_d.mode == MODE_TEST);
    end

    always_ff @(posedge tclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mode  <= MODE_OFF;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // reference gate changes while tclk is low, so no partial pulse
    always_ff @(negedge tclk or negedge rst_n) begin
        if (!rst_n) begin
            ref_run_q <= 1'b0;
        end else begin
            ref_run_q <= run_nxt;
        end
    end

    for (genvar g = 0; g < NPOW; g++) begin : g_pow
        tmr_half_div u_half (
            .clk      (tclk),
            .rst_n    (rst_n),
            .run_nxt  (run_nxt),
            .half_bit (st_d.phase[HB[g]]),
            .clk_o    (p2_clk[g])
        );
    end

    tmr_div3 #(.DIV(3)) u_div3 (
        .clk     (tclk),
        .rst_n   (rst_n),
        .run_nxt (run_nxt),
        .clk_o   (mid_clk)
    );

    assign cpu_clk     = p2_clk[0];
    assign sdram_clk   = p2_clk[1];
    assign usb_clk     = p2_clk[2];
    assign pci_clk     = p2_clk[3];
    assign apic_clk    = st_q.strap ? p2_clk[4] : p2_clk[5];
    assign ref_clk     = tclk & ref_run_q;
    assign grp_oe      = {NGROUP{st_q.mode != MODE_OFF}};
    assign normal_mode = (st_q.mode == MODE_RUN);

    // R9: mode moves only on the wrap edge of the shared phase counter
    p_mode_at_align_r9: assert property (@(posedge tclk) disable iff (!rst_n)
        !$stable(st_q.mode) |-> (st_q.phase == '0));

    // R2: disabled mode leaves every divider idle
    p_off_quiet_r2: assert property (@(posedge tclk) disable iff (!rst_n)
        (st_q.mode == MODE_OFF) |-> (p2_clk == '0 && !mid_clk));

    // R8: normal mode leaves every divider idle
    p_run_quiet_r8: assert property (@(posedge tclk) disable iff (!rst_n)
        (st_q.mode == MODE_RUN) |-> (p2_clk == '0 && !mid_clk));

    // R6: interrupt-controller edges land on peripheral-bus edges
    p_apic_on_pci_r6: assert property (@(posedge tclk) disable iff (!rst_n)
        $rose(apic_clk) |-> $rose(pci_clk));

    // R7: captured strap holds once armed clears
    p_strap_hold_r7: assert property (@(posedge tclk) disable iff (!rst_n)
        !st_q.armed |=> $stable(st_q.strap));
endmodule

// File: tb/tmr_ratio_div_tb.sv
module tmr_ratio_div_tb;
    logic       tclk  = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel   = 3'd0;
    logic       strap = 1'b0;
    logic cpu_clk, sdram_clk, usb_clk, mid_clk, pci_clk, ref_clk, apic_clk;
    logic [6:0] grp_oe;
    logic       normal_mode;

    tmr_ratio_div u_dut (
        .tclk(tclk), .rst_n(rst_n), .sel(sel), .strap(strap),
        .cpu_clk(cpu_clk), .sdram_clk(sdram_clk), .usb_clk(usb_clk),
        .mid_clk(mid_clk), .pci_clk(pci_clk), .ref_clk(ref_clk),
        .apic_clk(apic_clk), .grp_oe(grp_oe), .normal_mode(normal_mode)
    );

    always #5 tclk = ~tclk;

    int checks = 0;
    int errors = 0;
    int k = 0;
    logic [6:0] ca, cb;   // {apic, ref, pci, mid, usb, sdram, cpu}

    // {strap, sel[2:0], exp_oe, exp_normal, exp_run}
    localparam logic [6:0] VEC [9] = '{
        {1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
        {1'b0, 3'd1, 1'b1, 1'b0, 1'b1},
        {1'b1, 3'd1, 1'b1, 1'b0, 1'b1},
        {1'b0, 3'd2, 1'b1, 1'b1, 1'b0},
        {1'b1, 3'd3, 1'b1, 1'b1, 1'b0},
        {1'b0, 3'd4, 1'b1, 1'b1, 1'b0},
        {1'b1, 3'd5, 1'b1, 1'b1, 1'b0},
        {1'b0, 3'd6, 1'b1, 1'b1, 1'b0},
        {1'b0, 3'd7, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_clk(input int p, input bit second,
                                           input bit s, input bit run);
        logic [6:0] e;
        if (!run) return 7'd0;
        e[0] = (p % 2 == 0);
        e[1] = e[0];
        e[2] = e[0];
        e[3] = second ? (p % 3 == 0) : (p % 3 != 2);
        e[4] = (p % 8 < 4);
        e[5] = !second;
        e[6] = s ? (p % 8 < 4) : (p % 16 < 8);
        return e;
    endfunction

    task automatic step();
        @(posedge tclk);
        k++;
        #2;
        ca = {apic_clk, ref_clk, pci_clk, mid_clk, usb_clk, sdram_clk, cpu_clk};
        #5;
        cb = {apic_clk, ref_clk, pci_clk, mid_clk, usb_clk, sdram_clk, cpu_clk};
    endtask

    task automatic do_reset(input bit s, input logic [2:0] sv);
        rst_n = 1'b0;
        strap = s;
        sel   = sv;
        @(posedge tclk);
        @(posedge tclk);
        #3;
        rst_n = 1'b1;
        k = 0;
    endtask

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        sel   = 3'd1;
        @(posedge tclk);
        #2;
        chk("R1", "oe in reset", grp_oe, 7'd0);
        chk("R1", "normal in reset", normal_mode, 1'b0);
        chk("R1", "clocks in reset",
            {apic_clk, ref_clk, pci_clk, mid_clk, usb_clk, sdram_clk, cpu_clk}, 7'd0);

        for (int i = 0; i < 9; i++) begin
            logic       vs, voe, vnm, vrun;
            logic [2:0] vsel;
            int         mm [7];
            string      rq;
            {vs, vsel, voe, vnm, vrun} = VEC[i];
            do_reset(vs, vsel);
            while (k < 47) step();
            chk("R9", "oe before alignment", grp_oe, 7'd0);
            chk("R9", "clocks before alignment", ca, 7'd0);
            step();
            rq = vrun ? "R3" : (voe ? "R8" : "R2");
            chk(rq, "oe after alignment", grp_oe, {7{voe}});
            chk(rq, "normal flag", normal_mode, vnm);
            if (vrun) chk("R9", "all clocks rise at alignment", ca, 7'h7F);
            for (int g = 0; g < 7; g++) mm[g] = 0;
            for (int kk = 48; kk < 96; kk++) begin
                logic [6:0] ea, eb;
                if (kk > 48) step();
                ea = exp_clk(k % 48, 1'b0, vs, vrun);
                eb = exp_clk(k % 48, 1'b1, vs, vrun);
                for (int g = 0; g < 7; g++) begin
                    if (ca[g] !== ea[g] || cb[g] !== eb[g]) mm[g]++;
                end
            end
            for (int g = 0; g < 7; g++) begin
                string gr;
                if (!vrun) gr = rq;
                else if (g < 3) gr = "R3";
                else if (g == 3) gr = "R4";
                else if (g < 6) gr = "R5";
                else gr = "R6";
                chk(gr, $sformatf("vector %0d group %0d mismatches", i, g), mm[g], 0);
            end
        end

        // R7: strap change after capture is ignored
        do_reset(1'b1, 3'd1);
        step();
        step();
        strap = 1'b0;
        while (k < 52) step();
        chk("R7", "apic at phase 52 keeps /8", ca[6], 1'b0);
        while (k < 56) step();
        chk("R7", "apic at phase 56 keeps /8", ca[6], 1'b1);

        // R9: select change waits for the next alignment edge
        do_reset(1'b0, 3'd1);
        while (k < 60) step();
        sel = 3'd2;
        while (k < 94) step();
        chk("R9", "cpu still toggling before wrap", ca[0], 1'b1);
        step();
        chk("R9", "normal flag before wrap", normal_mode, 1'b0);
        step();
        chk("R9", "normal flag at wrap", normal_mode, 1'b1);
        chk("R8", "clocks low after wrap first half", ca, 7'd0);
        chk("R8", "clocks low after wrap second half", cb, 7'd0);
        while (k < 100) step();
        sel = 3'd0;
        while (k < 143) step();
        chk("R9", "oe held before wrap", grp_oe, 7'h7F);
        step();
        chk("R2", "oe off at wrap", grp_oe, 7'd0);
        chk("R2", "normal off at wrap", normal_mode, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule